// File: doc/BRIEF.md
# Pipelined Three-Product Recursive Integer Multiplier

This block returns the full 64-bit product of two unsigned 32-bit numbers. A schoolbook multiplier needs four half-width partial products. This block needs only three. For each operand it forms an upper half and a lower half. It then multiplies the two upper halves together and the two lower halves together. The third product multiplies the signed difference of one operand's halves by the signed difference of the other operand's halves. The three products are combined with fixed shifts and one add or subtract.

The same three-product split is used again inside each 16-bit product. This gives nine 8-by-8 array multipliers at the bottom. Each signed difference is carried as a magnitude and a sign bit. The sign of the middle product decides whether it is added or subtracted during recombination.

Operand pairs enter as a stream qualified by a valid bit. A new pair may arrive on every clock. Each result leaves, in order, with its own valid bit a fixed four cycles later. There is no stall path.

Top module: `kmul_top`

## Requirements
- R1: For every accepted pair (in_a, in_b), out_prod equals the exact unsigned product in_a × in_b, all 64 bits.
- R2: out_valid is high at a clock edge exactly when in_valid was high at the fourth edge before it, with no reset in between. In-valid gaps appear at the output as the same gaps, four cycles later.
- R3: The block accepts a pair on every clock with in_valid held high. Back-to-back results come out one per cycle, in arrival order.
- R4: Operands whose upper 16 bits equal their lower 16 bits make the middle difference zero. They still give the exact product.
- R5: The product is exact for every sign combination of the middle factors. The upper-half difference of in_a is negative when bits 31:16 are below bits 15:0. The lower-half difference of in_b is negative when bits 15:0 are below bits 31:16. Cases: neither, either one, or both negative.
- R6: The extreme operands 0 and 0xFFFFFFFF, in any combination, give exact products (0 and 0xFFFFFFFE00000001).
- R7: rst is active high and synchronous. An edge with rst high clears every valid stage. out_valid is low during reset, and pairs in flight or presented at that edge produce no output.
- R8: The recombination sum, kept two bits wider than the result at each level, never carries into those two extra bits for an accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of all valid stages |
| in_valid | input | 1 | Operand pair on in_a/in_b is present this cycle |
| in_a | input | 32 | First unsigned operand |
| in_b | input | 32 | Second unsigned operand |
| out_valid | output | 1 | out_prod holds a result this cycle |
| out_prod | output | 64 | Unsigned product of the pair accepted four cycles earlier |

## Verification
The operand patterns are chosen to separate the three partial products.

- Zero and all-ones operands exercise the largest carries and the outer combination weights.
- Operands with equal halves, at both recursion levels, null the middle term. Any error then comes from the outer products.
- Hand-picked halves drive each middle-factor sign combination: positive by positive, negative by positive, positive by negative, and negative by negative. These show whether the add/subtract choice is taken correctly.
- A gapped random stream, a gapless random stream and a reset in mid-stream check latency, ordering and flushing against a four-deep queue model.

// File: rtl/kmul_pkg.sv
package kmul_pkg;

  // Magnitude of the difference of two unsigned values (up to 32 bits).
  function automatic logic [31:0] mag_diff(input logic [31:0] x, input logic [31:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  // True when x - y is negative.
  function automatic logic is_below(input logic [31:0] x, input logic [31:0] y);
    return x < y;
  endfunction

  // Sign of the middle product: the signs of (a_hi - a_lo) and (b_lo - b_hi) combined.
  function automatic logic mid_sign(input logic [31:0] a_hi, input logic [31:0] a_lo,
                                    input logic [31:0] b_hi, input logic [31:0] b_lo);
    return is_below(a_hi, a_lo) ^ is_below(b_lo, b_hi);
  endfunction

endpackage

// File: rtl/kmul_split.sv
// One halving step: three operand pairs of half width plus the middle sign.
module kmul_split #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W/2-1:0] hi_a,
  output logic [W/2-1:0] hi_b,
  output logic [W/2-1:0] md_a,
  output logic [W/2-1:0] md_b,
  output logic [W/2-1:0] lo_a,
  output logic [W/2-1:0] lo_b,
  output logic           md_neg
);
  import kmul_pkg::*;

  localparam int H = W / 2;

  logic [H-1:0] a_up, a_dn, b_up, b_dn;

  always_comb begin
    a_up   = a[W-1:H];
    a_dn   = a[H-1:0];
    b_up   = b[W-1:H];
    b_dn   = b[H-1:0];
    hi_a   = a_up;
    hi_b   = b_up;
    lo_a   = a_dn;
    lo_b   = b_dn;
    md_a   = H'(mag_diff(32'(a_up), 32'(a_dn)));
    md_b   = H'(mag_diff(32'(b_dn), 32'(b_up)));
    md_neg = mid_sign(32'(a_up), 32'(a_dn), 32'(b_up), 32'(b_dn));
  end

endmodule

// File: rtl/kmul_base.sv
// Leaf array multiplier: sum of shifted, gated rows.
module kmul_base #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] row [W];

  for (genvar i = 0; i < W; i++) begin : g_row
    assign row[i] = b[i] ? (PW'(a) << i) : '0;
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) p = p + row[i];
  end

endmodule

// File: rtl/kmul_merge.sv
// Recombination of three sub-products of width W into a 2W result, with two guard bits.
module kmul_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0]     p_hi,
  input  logic [W-1:0]     p_mid,
  input  logic [W-1:0]     p_lo,
  input  logic             mid_neg,
  output logic [2*W+1:0]   ext
);
  localparam int SH = W / 2;
  localparam int EW = 2 * W + 2;

  logic [EW-1:0] e_hi, e_lo, e_mid, base, mid_sh;

  always_comb begin
    e_hi   = EW'(p_hi);
    e_lo   = EW'(p_lo);
    e_mid  = EW'(p_mid);
    base   = (e_hi << W) + (e_hi << SH) + (e_lo << SH) + e_lo;
    mid_sh = e_mid << SH;
    ext    = mid_neg ? (base - mid_sh) : (base + mid_sh);
  end

endmodule

// File: rtl/kmul_top.sv
// Four-stage pipelined two-level three-product multiplier.
module kmul_top #(
  parameter int OPW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             out_valid,
  output logic [2*OPW-1:0] out_prod
);
  localparam int HW = OPW / 2;   // first-level half
  localparam int QW = HW / 2;    // leaf operand width
  localparam int PQ = 2 * QW;    // leaf product width
  localparam int PH = 2 * HW;    // first-level product width
  localparam int NP = 3;         // sub-products per level: 0 high, 1 middle, 2 low

  // ---------------- stage 1: first split ----------------
  logic [HW-1:0] c1_a [NP];
  logic [HW-1:0] c1_b [NP];
  logic          c1_neg;

  kmul_split #(.W(OPW)) u_split_top (
    .a(in_a), .b(in_b),
    .hi_a(c1_a[0]), .hi_b(c1_b[0]),
    .md_a(c1_a[1]), .md_b(c1_b[1]),
    .lo_a(c1_a[2]), .lo_b(c1_b[2]),
    .md_neg(c1_neg)
  );

  logic          s1_valid, s1_neg;
  logic [HW-1:0] s1_a [NP];
  logic [HW-1:0] s1_b [NP];

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_neg <= c1_neg;
    for (int i = 0; i < NP; i++) begin
      s1_a[i] <= c1_a[i];
      s1_b[i] <= c1_b[i];
    end
  end

  // ---------------- stage 2: second split ----------------
  logic [QW-1:0] c2_a [NP][NP];
  logic [QW-1:0] c2_b [NP][NP];
  logic          c2_neg [NP];

  for (genvar i = 0; i < NP; i++) begin : g_split
    kmul_split #(.W(HW)) u_split (
      .a(s1_a[i]), .b(s1_b[i]),
      .hi_a(c2_a[i][0]), .hi_b(c2_b[i][0]),
      .md_a(c2_a[i][1]), .md_b(c2_b[i][1]),
      .lo_a(c2_a[i][2]), .lo_b(c2_b[i][2]),
      .md_neg(c2_neg[i])
    );
  end

  logic          s2_valid, s2_neg_top;
  logic          s2_neg [NP];
  logic [QW-1:0] s2_a [NP][NP];
  logic [QW-1:0] s2_b [NP][NP];

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_neg_top <= s1_neg;
    for (int i = 0; i < NP; i++) begin
      s2_neg[i] <= c2_neg[i];
      for (int j = 0; j < NP; j++) begin
        s2_a[i][j] <= c2_a[i][j];
        s2_b[i][j] <= c2_b[i][j];
      end
    end
  end

  // ---------------- stage 3: leaf products ----------------
  logic [PQ-1:0] c3_p [NP][NP];

  for (genvar i = 0; i < NP; i++) begin : g_leaf_i
    for (genvar j = 0; j < NP; j++) begin : g_leaf_j
      kmul_base #(.W(QW)) u_base (
        .a(s2_a[i][j]), .b(s2_b[i][j]), .p(c3_p[i][j])
      );
    end
  end

  logic          s3_valid, s3_neg_top;
  logic          s3_neg [NP];
  logic [PQ-1:0] s3_p [NP][NP];

  always_ff @(posedge clk) begin
    if (rst) s3_valid <= 1'b0;
    else     s3_valid <= s2_valid;
    s3_neg_top <= s2_neg_top;
    for (int i = 0; i < NP; i++) begin
      s3_neg[i] <= s2_neg[i];
      for (int j = 0; j < NP; j++) s3_p[i][j] <= c3_p[i][j];
    end
  end

  // ---------------- stage 4: two-level recombination ----------------
  logic [2*PQ+1:0] inner_ext [NP];
  logic [PQ*2-1:0] inner_p   [NP];
  logic [NP-1:0]   inner_spill;
  logic [2*PH+1:0] outer_ext;
  logic            outer_spill;

  for (genvar i = 0; i < NP; i++) begin : g_merge
    kmul_merge #(.W(PQ)) u_merge (
      .p_hi(s3_p[i][0]), .p_mid(s3_p[i][1]), .p_lo(s3_p[i][2]),
      .mid_neg(s3_neg[i]), .ext(inner_ext[i])
    );
    assign inner_p[i]     = inner_ext[i][2*PQ-1:0];
    assign inner_spill[i] = |inner_ext[i][2*PQ+1:2*PQ];
  end

  kmul_merge #(.W(PH)) u_merge_top (
    .p_hi(inner_p[0]), .p_mid(inner_p[1]), .p_lo(inner_p[2]),
    .mid_neg(s3_neg_top), .ext(outer_ext)
  );
  assign outer_spill = |outer_ext[2*PH+1:2*PH];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s3_valid;
    out_prod <= outer_ext[2*PH-1:0];
  end

  // ---------------- assertions ----------------
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    s3_valid |-> (inner_spill == '0) && !outer_spill);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4 && out_valid) |->
      (out_prod == (2*OPW)'($past(in_a, 4)) * (2*OPW)'($past(in_b, 4))));

  assert_mid_bound_R5: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (s1_a[1] <= s1_a[0] || s1_a[1] <= s1_a[2]) &&
                 (s1_b[1] <= s1_b[0] || s1_b[1] <= s1_b[2]));

  assert_equal_halves_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_a[0] == s1_a[2]) |-> (s1_a[1] == '0));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: tb/test_kmul_top.sv
module test_kmul_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_prod;

  int    n_vec  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  string cur_tag = "R7";

  always #10 clk = ~clk;   // 50 MHz

  kmul_top i_kmul_top (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  // Reference: four-deep queue of what each edge accepted.
  bit          q_v [$] = '{0, 0, 0, 0};
  logic [63:0] q_p [$] = '{0, 0, 0, 0};
  string       q_t [$] = '{"R7", "R7", "R7", "R7"};

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      q_v = '{0, 0, 0, 0};
      q_p = '{0, 0, 0, 0};
      q_t = '{"R7", "R7", "R7", "R7"};
    end else begin
      q_v.push_front(in_valid);
      q_p.push_front({32'd0, in_a} * {32'd0, in_b});
      q_t.push_front(cur_tag);
      void'(q_v.pop_back());
      void'(q_p.pop_back());
      void'(q_t.pop_back());
    end
  end

  always @(negedge clk) begin
    n_vec++;
    if (out_valid !== q_v[3]) begin
      n_fail++;
      $display("FAIL %s valid: actual %b expected %b", q_t[3], out_valid, q_v[3]);
    end else if (q_v[3] && out_prod !== q_p[3]) begin
      n_fail++;
      $display("FAIL %s product: actual %h expected %h", q_t[3], out_prod, q_p[3]);
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] b, input string t);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; cur_tag = t;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_a = $urandom; in_b = $urandom; cur_tag = "R2";
    end
  endtask

  initial begin
    // R7: outputs held invalid during reset
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R6: extremes
    send(32'h0, 32'h0, "R6");
    send(32'h0, 32'hFFFF_FFFF, "R6");
    send(32'hFFFF_FFFF, 32'h0, "R6");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    // R8: largest sums at each level
    send(32'hFFFF_FFFF, 32'hFFFF_0000, "R8");
    send(32'hFF00_FFFF, 32'hFFFF_00FF, "R8");
    idle(1);

    // R4: equal halves, at one and both levels
    send(32'h1234_1234, 32'hABCD_ABCD, "R4");
    send(32'h5A5A_5A5A, 32'hC3C3_C3C3, "R4");
    send(32'h8001_8001, 32'h0000_0000, "R4");
    idle(1);

    // R5: middle sign combinations
    send(32'h0005_0003, 32'h0003_0005, "R5"); // both non-negative
    send(32'h0001_FFFF, 32'h0003_0005, "R5"); // a side negative
    send(32'h0005_0003, 32'hFFFF_0001, "R5"); // b side negative
    send(32'h0001_FFFF, 32'hFFFF_0001, "R5"); // both negative
    send(32'h00FF_FF00, 32'hF00F_0FF0, "R5");
    idle(1);

    // R7: reset with pairs in flight and one presented at the reset edge
    send(32'hDEAD_BEEF, 32'h1234_5678, "R7");
    send(32'hCAFE_F00D, 32'h8765_4321, "R7");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; cur_tag = "R7";
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    idle(5);

    // R3: gapless random stream
    for (int k = 0; k < 300; k++) send($urandom, $urandom, "R3");

    // R2: random stream with gaps
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(2) == 0) idle(1);
      else send($urandom, $urandom, "R2");
    end

    // R1: random halves biased toward sign flips
    for (int k = 0; k < 300; k++)
      send({$urandom_range(65535) & 16'h00FF, 16'(($urandom))},
           {16'($urandom), $urandom_range(65535) & 16'h0F0F}, "R1");

    idle(6);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule